// File: doc/BRIEF.md
# ADC conversion start and scan sequencer

This block sits between system software and a successive-approximation converter core. It decides when conversions begin, which channel each one samples, and at what rate the core is paced. Software programs an 8-bit control register over a plain write/read port. The register selects the start source, the operating mode, the clock divisor and whether continuous scanning stops after one pass. Conversions are launched by a software set of the start bit, or by a pulse from one of two timer units, whichever the trigger field allows.

The core is modelled as a request/done handshake. The sequencer raises `conv_req` with a channel number on `conv_ch`, and the core answers with a one-cycle `conv_done`. The sequencer opens each conversion only on a conversion-clock enable pulse, which it derives from the system clock divided by 1, 2, 4 or 8. In single mode it converts the channel chosen on `chan_sel` once and then goes idle. In scan mode it walks from channel 0 up to the highest selected channel. That channel comes from `chan_sel[1:0]` for the four-channel group, or from `chan_sel[2:0]` for the eight-channel group. After the last channel it emits `pass_end` and either starts the pass again or stops by itself.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0x00, and `busy`, `conv_req` and `pass_end` are low.
- R2: Control bit 0 always reads as 0, whatever value is written to it.
- R3: The clock field (bits 3:2) and the mode field (bits 5:4) can be written only while `busy` is 0; writes to them while busy leave them unchanged. The trigger field (bits 7:6) and the auto-stop bit (bit 1) accept writes at any time.
- R4: A trigger field value of 01 lets a `trig_a` pulse set `busy`, and 10 lets a `trig_b` pulse set `busy`. The other timer's pulse has no effect in either case. Values 00 and 11 let neither pulse start a conversion.
- R5: A timer pulse that arrives while `busy` is 1 is dropped: it does not cause an extra conversion after the current work ends.
- R6: Clock field k (0..3) divides by 2^k. The first `conv_req` rises 2^k clock edges after the edge that sets `busy`, and each conversion opens only on a conversion-clock enable.
- R7: In single mode (bit 5 = 0), one conversion runs on channel `chan_sel`. Then `busy` clears, and no `pass_end` is produced.
- R8: In scan mode (bit 5 = 1), channels are converted in ascending order from 0. The last channel is `chan_sel[1:0]` when bit 4 = 0, or `chan_sel[2:0]` when bit 4 = 1.
- R9: `pass_end` is high for exactly one cycle, in the cycle after the last channel of a scan pass completes.
- R10: With bit 1 = 1, a scan stops by itself after one pass and `busy` clears. With bit 1 = 0, the scan restarts at channel 0 and `busy` stays 1.
- R11: A `sw_start_clr` pulse aborts activity: `busy` and `conv_req` drop at the next edge. When set and clear arrive together, clear wins.
- R12: `conv_ch` holds steady while `conv_req` is high. A `conv_done` while `conv_req` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| sw_start_set | input | 1 | Software pulse that sets the start bit |
| sw_start_clr | input | 1 | Software pulse that clears the start bit |
| trig_a | input | 1 | Start pulse from timer unit A |
| trig_b | input | 1 | Start pulse from timer unit B |
| chan_sel | input | 3 | Single-mode channel, or highest scan channel |
| busy | output | 1 | Start bit: conversion activity in progress |
| conv_clk_en | output | 1 | Conversion clock enable pulse |
| conv_req | output | 1 | Conversion request to the converter core |
| conv_ch | output | 3 | Channel for the current request |
| conv_done | input | 1 | Conversion complete pulse from the core |
| pass_end | output | 1 | One-cycle strobe at the end of a scan pass |

## Verification
The sequencer is driven with single conversions at each of the four divisors. Measuring the start-to-request delay separates the divide ratios from one another and from an enable that is stuck high. Four-channel and eight-channel scans are run with a `chan_sel` whose upper bit conflicts with the group size, which shows whether the group width masks the selector. Scans with and without auto-stop, timer pulses under every trigger code, and stray done or trigger pulses at idle moments separate the stop, restart and drop behaviours from the paths that actually start or end work.

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int CH_W  = 3,
  parameter int DIV_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  output logic [7:0]      rd_data,
  input  logic            sw_start_set,
  input  logic            sw_start_clr,
  input  logic            trig_a,
  input  logic            trig_b,
  input  logic [CH_W-1:0] chan_sel,
  output logic            busy,
  output logic            conv_clk_en,
  output logic            conv_req,
  output logic [CH_W-1:0] conv_ch,
  input  logic            conv_done,
  output logic            pass_end
);

  logic [7:1]       ctrl;
  logic             start, req, pass_q;
  logic [CH_W-1:0]  ch;
  logic [DIV_W-1:0] cnt, mask;

  wire [1:0] trg   = ctrl[7:6];
  wire       scan  = ctrl[5];
  wire       grp8  = ctrl[4];
  wire [1:0] cks   = ctrl[3:2];
  wire       aclr  = ctrl[1];

  assign mask = DIV_W'({cks == 2'd3, cks[1], cks != 2'd0});
  assign conv_clk_en = start && ((cnt & mask) == mask);

  wire [CH_W-1:0] hi = grp8 ? chan_sel : {1'b0, chan_sel[1:0]};
  wire last     = !scan || (ch == hi);
  wire trig_hit = (trg == 2'b01 && trig_a) || (trg == 2'b10 && trig_b);
  wire fin      = req && conv_done;
  wire end_clr  = fin && last && (!scan || aclr);

  assign rd_data  = {ctrl, 1'b0};
  assign busy     = start;
  assign conv_req = req;
  assign conv_ch  = ch;
  assign pass_end = pass_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl <= '0;
    else if (wr_en) begin
      ctrl[7:6] <= wr_data[7:6];
      ctrl[1]   <= wr_data[1];
      if (!start) ctrl[5:2] <= wr_data[5:2];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) start <= 1'b0;
    else if (sw_start_clr || end_clr) start <= 1'b0;
    else if (sw_start_set || (!start && trig_hit)) start <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (!start) cnt <= '0;
    else cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ch <= '0;
    else if (!start) ch <= scan ? '0 : chan_sel;
    else if (fin) ch <= last ? '0 : ch + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) req <= 1'b0;
    else if (!start || sw_start_clr || fin) req <= 1'b0;
    else if (conv_clk_en) req <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pass_q <= 1'b0;
    else pass_q <= fin && last && scan;

  assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && $past(start)) |-> $stable(ctrl[5:2]));

  assert_req_on_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_req) |-> $past(conv_clk_en));

  assert_pass_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end |=> !pass_end);

  assert_req_needs_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> busy);

  assert_ch_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done) |=> (!conv_req || $stable(conv_ch)));

endmodule

// File: tb/adc_scan_ctrl_test.sv
module adc_scan_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, sw_start_set = 0, sw_start_clr = 0;
  logic trig_a = 0, trig_b = 0, conv_done = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] chan_sel = 0;
  logic [7:0] rd_data;
  logic busy, conv_clk_en, conv_req, pass_end;
  logic [2:0] conv_ch;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  adc_scan_ctrl uut (.clk, .rst_n, .wr_en, .wr_data, .rd_data, .sw_start_set,
    .sw_start_clr, .trig_a, .trig_b, .chan_sel, .busy, .conv_clk_en,
    .conv_req, .conv_ch, .conv_done, .pass_end);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic write_ctrl(input logic [7:0] d);
    wr_en = 1; wr_data = d; @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse_set; sw_start_set = 1; @(negedge clk); sw_start_set = 0; endtask
  task automatic pulse_clr; sw_start_clr = 1; @(negedge clk); sw_start_clr = 0; endtask

  task automatic serve(output int ch, output bit pe);
    int n = 0;
    while (!conv_req && n < 60) begin @(negedge clk); n++; end
    ch = conv_req ? int'(conv_ch) : -1;
    conv_done = 1; @(negedge clk); conv_done = 0;
    pe = pass_end;
  endtask

  task automatic t_reset;
    check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    check(!busy && !conv_req && !pass_end, "R1 outputs low", {busy, conv_req, pass_end}, 0);
    write_ctrl(8'hFF);
    check(rd_data == 8'hFE, "R2 bit0 reads zero", rd_data, 8'hFE);
    write_ctrl(8'h00);
  endtask

  task automatic t_divider;
    for (int k = 0; k < 4; k++) begin
      int n = 0, ch; bit pe;
      write_ctrl(8'(k << 2));
      chan_sel = 3'(k + 4);
      pulse_set;
      while (!conv_req && n < 40) begin
        if (k == 3 && n == 2) conv_done = 1;
        @(negedge clk); conv_done = 0; n++;
      end
      check(n == (1 << k), "R6 first request delay", n, 1 << k);
      if (k == 3) check(busy == 1, "R12 early done ignored", busy, 1);
      serve(ch, pe);
      check(ch == k + 4, "R7 single channel", ch, k + 4);
      check(!busy && !pe, "R7 single ends without pass_end", {busy, pe}, 0);
    end
  endtask

  task automatic t_scan(input logic [7:0] cfg, input logic [2:0] sel, input int top, input string tag);
    int ch; bit pe;
    write_ctrl(cfg); chan_sel = sel; pulse_set;
    for (int i = 0; i <= top; i++) begin
      serve(ch, pe);
      check(ch == i, {"R8 order ", tag}, ch, i);
      check(pe == (i == top), "R9 pass_end at last", pe, i == top);
    end
    @(negedge clk);
    check(!pass_end, "R9 pass_end one cycle", pass_end, 0);
    check(busy == 0, "R10 auto-stop clears busy", busy, 0);
  endtask

  task automatic t_repeat;
    int ch; bit pe;
    write_ctrl(8'h20); chan_sel = 3'd1; pulse_set;
    serve(ch, pe); serve(ch, pe);
    check(pe && busy, "R10 repeat keeps busy", {pe, busy}, 3);
    serve(ch, pe);
    check(ch == 0, "R10 restart at channel 0", ch, 0);
    write_ctrl(8'hDF);
    check(rd_data == 8'hE2, "R3 frozen fields while busy", rd_data, 8'hE2);
    pulse_clr;
    check(!busy && !conv_req, "R11 abort", {busy, conv_req}, 0);
    sw_start_set = 1; sw_start_clr = 1; @(negedge clk);
    sw_start_set = 0; sw_start_clr = 0;
    check(!busy, "R11 clear wins", busy, 0);
    write_ctrl(8'h00);
  endtask

  task automatic t_trig;
    logic [1:0] sel [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
    for (int i = 0; i < 4; i++) begin
      int ch; bit pe;
      write_ctrl({sel[i], 6'h00}); chan_sel = 3'd2;
      trig_a = 1; @(negedge clk); trig_a = 0;
      check(busy == (sel[i] == 2'b01), "R4 trig_a", busy, sel[i] == 2'b01);
      if (busy) begin serve(ch, pe); check(ch == 2, "R4 triggered conversion", ch, 2); end
      trig_b = 1; @(negedge clk); trig_b = 0;
      check(busy == (sel[i] == 2'b10), "R4 trig_b", busy, sel[i] == 2'b10);
      if (busy) serve(ch, pe);
    end
  endtask

  task automatic t_drop;
    int ch; bit pe; int n = 0;
    write_ctrl(8'h4C); chan_sel = 3'd3;
    trig_a = 1; @(negedge clk); trig_a = 0;
    while (!conv_req && n < 40) begin @(negedge clk); n++; end
    trig_a = 1; @(negedge clk); trig_a = 0;
    serve(ch, pe);
    repeat (12) @(negedge clk);
    check(!busy && !conv_req, "R5 pulse during conversion dropped", {busy, conv_req}, 0);
    write_ctrl(8'h00);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_divider;
    t_scan(8'h22, 3'b110, 2, "group4");
    t_scan(8'h32, 3'b101, 5, "group8");
    t_scan(8'h26, 3'b011, 3, "group4 div2");
    t_repeat;
    t_trig;
    t_drop;
    finished = 1;
    report;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report;
    end
  end
endmodule